// File: doc/BRIEF.md
# Periodic-Preamble Frame Detector

This block watches a stream of complex baseband samples for the start of a burst whose training section repeats every 16 samples. For each accepted sample it forms the product of that sample with the conjugate of the sample 16 accepted samples earlier. It keeps a running sum of that product over the last 16 samples, and a running sum of the instantaneous power over the same 16 samples. When the lag correlation is large compared with the received energy, the input is locally periodic, whatever its level. The comparison is done without a divider: the squared correlation magnitude, scaled by 16, is compared with a programmable threshold times the squared energy.

A single crossing is not enough. The test has to hold on a run of consecutive samples before a one-cycle detect pulse is issued. At that pulse the complex correlation is captured and held on the outputs, so that a later stage can take its angle as a coarse carrier-offset estimate (offset = fs·angle / (2π·16)). After a detection the block stays quiet until the downstream receiver reports that the frame has been handled.

Top module: `preamble_sync_detector`

## Requirements
- R1: While reset is high and on the first cycle after it, `detect` is 0 and `corr_re`/`corr_im` are 0.
- R2: A clean 16-periodic burst of 160 samples, preceded by noise, produces exactly one `detect` pulse. The pulse is seen no earlier than 32 accepted samples after the burst starts and no later than 15 accepted samples after it ends.
- R3: With `thr` = 8, uncorrelated random input and all-zero input never raise `detect`. A window with zero energy never passes the test.
- R4: At the detect pulse, `corr_re`/`corr_im` carry Σ r[n−k]·conj(r[n−k−16]) for k = 0..15. For a clean periodic burst with per-period energy E this is (E, 0). When each period is the previous one turned by +90° (multiplied by j) it is (0, +E). Both outputs keep their value until the next detect pulse.
- R5: A window passes when 16·|P|² > thr·E², where P is the correlation and E the windowed energy. `detect` needs 32 consecutive passing accepted samples, and a failing sample restarts the run. A periodic burst of only 40 samples is therefore never detected.
- R6: `thr` is a 4-bit unsigned value. With `thr` = 15 a clean periodic burst is still detected. With `thr` = 0 any non-zero correlation passes, so random input is detected.
- R7: After a detect pulse, further passing input raises no new pulse until `frame_done` is high for a cycle. After that a new burst is detected again.
- R8: Samples presented with `in_valid` low are ignored: the data on `in_i`/`in_q` in those cycles leaves the running sums, the lag line and the detection result unchanged.
- R9: `detect` is high for exactly one cycle per detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the sample on `in_i`/`in_q` |
| in_i | input | SAMPLE_W | In-phase sample, two's complement |
| in_q | input | SAMPLE_W | Quadrature sample, two's complement |
| thr | input | THR_W | Threshold numerator; the ratio tested is thr/16 |
| frame_done | input | 1 | Re-arms the detector after a detection |
| detect | output | 1 | One-cycle pulse at frame detection |
| corr_re | output | SUM_W | Real part of the captured lag correlation |
| corr_im | output | SUM_W | Imaginary part of the captured lag correlation |

## Verification
The running sums are updated by adding and subtracting, so a single wrong stored product or a lag line that is out of step leaves a permanent offset in the sums. That offset shows up at the next detection as a captured correlation that is not exactly (E, 0) or (0, E), which the bench checks to the unit. A run counter or lock flag in the wrong state shows up within one burst as a missing, early, late or repeated pulse. The bench therefore measures pulse position against the burst boundaries and counts pulses across re-arm and non-re-arm sequences. Gapped input with garbage data checks that idle cycles leave no trace on the next capture.

// File: rtl/preamble_det_pkg.sv
package preamble_det_pkg;

  localparam int SAMPLE_W_DEF = 12;
  localparam int LAG_DEF      = 16;
  localparam int WIN_DEF      = 16;
  localparam int PERSIST_DEF  = 32;
  localparam int THR_W_DEF    = 4;
  localparam int N_LANES      = 3;

  typedef enum logic {
    ST_ARMED = 1'b0,
    ST_HELD  = 1'b1
  } lock_state_e;

endpackage

// File: rtl/ac_delay_line.sv
module ac_delay_line #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [DEPTH-1:0][W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else if (en) begin
      stage_q[0] <= din;
      for (int k = 1; k < DEPTH; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/ac_window_sum.sv
module ac_window_sum #(
  parameter int IN_W  = 25,
  parameter int OUT_W = 29,
  parameter int LEN   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] sum
);

  logic [IN_W-1:0]         old_raw;
  logic signed [OUT_W-1:0] new_x, old_x, sum_q;

  ac_delay_line #(.W(IN_W), .DEPTH(LEN)) u_hist (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .din  (din),
    .dout (old_raw)
  );

  assign new_x = {{(OUT_W-IN_W){din[IN_W-1]}}, din};
  assign old_x = {{(OUT_W-IN_W){old_raw[IN_W-1]}}, old_raw};

  always_ff @(posedge clk) begin
    if (rst)     sum_q <= '0;
    else if (en) sum_q <= sum_q + new_x - old_x;
  end

  assign sum = sum_q;

  // R8: idle cycles leave the running sum untouched
  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(sum_q));

endmodule

// File: rtl/ac_plateau_decide.sv
module ac_plateau_decide
  import preamble_det_pkg::*;
#(
  parameter int SUM_W   = 29,
  parameter int THR_W   = 4,
  parameter int PERSIST = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd,
  input  logic signed [SUM_W-1:0] p_re,
  input  logic signed [SUM_W-1:0] p_im,
  input  logic signed [SUM_W-1:0] e_pow,
  input  logic [THR_W-1:0]        thr,
  input  logic                    frame_done,
  output logic                    detect,
  output logic signed [SUM_W-1:0] corr_re,
  output logic signed [SUM_W-1:0] corr_im
);

  localparam int MW    = 2*SUM_W + THR_W + 2;
  localparam int CNT_W = $clog2(PERSIST + 1);

  logic signed [MW-1:0] re_x, im_x, e_x, thr_x, mag2, lhs, rhs;
  logic                 pass;
  lock_state_e          state_q;
  logic [CNT_W-1:0]     run_cnt_q;
  logic                 detect_q;
  logic signed [SUM_W-1:0] corr_re_q, corr_im_q;

  assign re_x  = {{(MW-SUM_W){p_re[SUM_W-1]}}, p_re};
  assign im_x  = {{(MW-SUM_W){p_im[SUM_W-1]}}, p_im};
  assign e_x   = {{(MW-SUM_W){e_pow[SUM_W-1]}}, e_pow};
  assign thr_x = {{(MW-THR_W){1'b0}}, thr};
  assign mag2  = re_x*re_x + im_x*im_x;
  assign lhs   = mag2 <<< THR_W;
  assign rhs   = thr_x * e_x * e_x;
  assign pass  = (lhs > rhs);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_ARMED;
      run_cnt_q <= '0;
      detect_q  <= 1'b0;
      corr_re_q <= '0;
      corr_im_q <= '0;
    end else begin
      detect_q <= 1'b0;
      if (state_q == ST_HELD) begin
        run_cnt_q <= '0;
        if (frame_done) state_q <= ST_ARMED;
      end else if (upd) begin
        if (!pass) begin
          run_cnt_q <= '0;
        end else if (run_cnt_q == CNT_W'(PERSIST-1)) begin
          detect_q  <= 1'b1;
          state_q   <= ST_HELD;
          run_cnt_q <= '0;
          corr_re_q <= p_re;
          corr_im_q <= p_im;
        end else begin
          run_cnt_q <= run_cnt_q + 1'b1;
        end
      end
    end
  end

  assign detect  = detect_q;
  assign corr_re = corr_re_q;
  assign corr_im = corr_im_q;

  // R9: a detection is a single-cycle pulse
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    detect_q |=> !detect_q);

  // R7: while held and not released, no further pulse
  assert_held_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HELD && !frame_done) |=> !detect_q);

  // R5: the run counter stays below the required run length
  assert_run_bound_R5: assert property (@(posedge clk) disable iff (rst)
    run_cnt_q < CNT_W'(PERSIST));

  // R4: captured correlation changes only together with a pulse
  assert_corr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !detect_q |-> ($stable(corr_re_q) && $stable(corr_im_q)));

  // R3: a pulse never follows a zero-energy window
  assert_no_zero_energy_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(detect_q) |-> ($past(e_pow) != '0));

endmodule

// File: rtl/preamble_sync_detector.sv
module preamble_sync_detector
  import preamble_det_pkg::*;
#(
  parameter int SAMPLE_W = SAMPLE_W_DEF,
  parameter int LAG      = LAG_DEF,
  parameter int WIN      = WIN_DEF,
  parameter int PERSIST  = PERSIST_DEF,
  parameter int THR_W    = THR_W_DEF,
  localparam int PROD_W  = 2*SAMPLE_W + 1,
  localparam int SUM_W   = PROD_W + $clog2(WIN)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_i,
  input  logic signed [SAMPLE_W-1:0] in_q,
  input  logic [THR_W-1:0]           thr,
  input  logic                       frame_done,
  output logic                       detect,
  output logic signed [SUM_W-1:0]    corr_re,
  output logic signed [SUM_W-1:0]    corr_im
);

  logic [2*SAMPLE_W-1:0]      lag_out;
  logic signed [PROD_W-1:0]   ci, cq, di, dq;
  logic signed [PROD_W-1:0]   prod_re, prod_im, pow;
  logic signed [PROD_W-1:0]   lane_in  [N_LANES];
  logic signed [SUM_W-1:0]    lane_sum [N_LANES];
  logic                       vld_q;

  // Sample from LAG accepted samples ago
  ac_delay_line #(.W(2*SAMPLE_W), .DEPTH(LAG)) u_lag (
    .clk  (clk),
    .rst  (rst),
    .en   (in_valid),
    .din  ({in_i, in_q}),
    .dout (lag_out)
  );

  assign ci = {{(PROD_W-SAMPLE_W){in_i[SAMPLE_W-1]}}, in_i};
  assign cq = {{(PROD_W-SAMPLE_W){in_q[SAMPLE_W-1]}}, in_q};
  assign di = {{(PROD_W-SAMPLE_W){lag_out[2*SAMPLE_W-1]}}, lag_out[2*SAMPLE_W-1:SAMPLE_W]};
  assign dq = {{(PROD_W-SAMPLE_W){lag_out[SAMPLE_W-1]}}, lag_out[SAMPLE_W-1:0]};

  // current * conj(lagged), and current power
  assign prod_re = ci*di + cq*dq;
  assign prod_im = cq*di - ci*dq;
  assign pow     = ci*ci + cq*cq;

  assign lane_in[0] = prod_re;
  assign lane_in[1] = prod_im;
  assign lane_in[2] = pow;

  for (genvar gl = 0; gl < N_LANES; gl++) begin : g_lane
    ac_window_sum #(.IN_W(PROD_W), .OUT_W(SUM_W), .LEN(WIN)) u_sum (
      .clk (clk),
      .rst (rst),
      .en  (in_valid),
      .din (lane_in[gl]),
      .sum (lane_sum[gl])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= in_valid;
  end

  ac_plateau_decide #(.SUM_W(SUM_W), .THR_W(THR_W), .PERSIST(PERSIST)) u_decide (
    .clk        (clk),
    .rst        (rst),
    .upd        (vld_q),
    .p_re       (lane_sum[0]),
    .p_im       (lane_sum[1]),
    .e_pow      (lane_sum[2]),
    .thr        (thr),
    .frame_done (frame_done),
    .detect     (detect),
    .corr_re    (corr_re),
    .corr_im    (corr_im)
  );

  // R4/R8: the power window is never negative
  assert_energy_nonneg_R4: assert property (@(posedge clk) disable iff (rst)
    !lane_sum[2][SUM_W-1]);

endmodule

// File: tb/preamble_sync_detector_tb.sv
module preamble_sync_detector_tb;

  localparam int SW    = 12;
  localparam int SUM_W = 2*SW + 1 + 4;
  localparam int NA    = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [SW-1:0] in_i = '0, in_q = '0;
  logic [3:0] thr = 4'd8;
  logic frame_done = 1'b0;
  logic detect;
  logic signed [SUM_W-1:0] corr_re, corr_im;

  int checks = 0, errors = 0;
  int n_valid = 0;
  int det_count = 0, det_idx = 0, pulse_bad = 0;
  longint cap_re = 0, cap_im = 0;
  bit prev_det = 1'b0, done = 1'b0;
  int pat_i [16], pat_q [16];
  longint e_per = 0;

  always #2 clk = ~clk;

  preamble_sync_detector u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .thr(thr), .frame_done(frame_done), .detect(detect),
    .corr_re(corr_re), .corr_im(corr_im)
  );

  always @(negedge clk) begin
    if (detect) begin
      det_count++;
      det_idx = n_valid;
      cap_re  = longint'(corr_re);
      cap_im  = longint'(corr_im);
      if (prev_det) pulse_bad++;
    end
    prev_det = detect;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input int vi, input int vq, input bit v);
    @(posedge clk); #1;
    in_valid = v;
    in_i = vi[SW-1:0];
    in_q = vq[SW-1:0];
    if (v) n_valid++;
  endtask

  function automatic int rnd(input int a);
    return int'($urandom_range(2*a)) - a;
  endfunction

  task automatic noise(input int n);
    for (int k = 0; k < n; k++) drive(rnd(NA), rnd(NA), 1'b1);
  endtask

  task automatic zeros(input int n);
    for (int k = 0; k < n; k++) drive(0, 0, 1'b1);
  endtask

  // periodic burst; rot turns each period +90 degrees from the previous one;
  // gaps inserts invalid cycles with garbage data
  task automatic burst(input int len, input bit rot, input bit gaps);
    for (int n = 0; n < len; n++) begin
      int vi, vq, t;
      vi = pat_i[n % 16];
      vq = pat_q[n % 16];
      if (rot) for (int r = 0; r < (n/16) % 4; r++) begin t = vi; vi = -vq; vq = t; end
      if (gaps && ($urandom_range(3) == 0)) drive(rnd(2000), rnd(2000), 1'b0);
      drive(vi, vq, 1'b1);
    end
  endtask

  task automatic release_lock();
    @(posedge clk); #1; frame_done = 1'b1; in_valid = 1'b0;
    @(posedge clk); #1; frame_done = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); #1; in_valid = 1'b0; end
  endtask

  initial begin
    int start, base;
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 16; k++) begin
      pat_i[k] = rnd(600);
      pat_q[k] = rnd(600);
      e_per += longint'(pat_i[k]*pat_i[k] + pat_q[k]*pat_q[k]);
    end

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check(detect == 1'b0, "R1 detect in reset", detect, 0);
    rst = 1'b0;
    @(negedge clk);
    check(detect == 1'b0, "R1 detect after reset", detect, 0);
    check(corr_re == 0 && corr_im == 0, "R1 corr after reset", longint'(corr_re), 0);

    // R3: noise and zeros never detect
    noise(400);
    idle(3);
    check(det_count == 0, "R3 random noise", det_count, 0);
    zeros(100);
    idle(3);
    check(det_count == 0, "R3 zero input", det_count, 0);

    // R2 + R4: clean burst after noise
    noise(50);
    start = n_valid;
    burst(160, 1'b0, 1'b0);
    noise(60);
    idle(3);
    check(det_count == 1, "R2 one pulse for burst", det_count, 1);
    check(det_idx >= start + 32 && det_idx <= start + 175, "R2 pulse position", det_idx - start, 64);
    check(cap_re == e_per, "R4 corr_re clean", cap_re, e_per);
    check(cap_im == 0, "R4 corr_im clean", cap_im, 0);
    check(pulse_bad == 0, "R9 pulse width", pulse_bad, 0);

    // R7: second burst without release is ignored
    burst(160, 1'b0, 1'b0);
    noise(40);
    idle(3);
    check(det_count == 1, "R7 held ignores burst", det_count, 1);
    check(longint'(corr_re) == e_per, "R4 corr held", longint'(corr_re), e_per);

    // R7 re-arm + R4 rotated burst
    release_lock();
    noise(40);
    base = det_count;
    burst(160, 1'b1, 1'b0);
    noise(40);
    idle(3);
    check(det_count == base + 1, "R7 rearmed detects", det_count, base + 1);
    check(cap_re == 0, "R4 corr_re rotated", cap_re, 0);
    check(cap_im == e_per, "R4 corr_im rotated", cap_im, e_per);

    // R5: short burst not detected
    release_lock();
    noise(40);
    base = det_count;
    burst(40, 1'b0, 1'b0);
    noise(100);
    idle(3);
    check(det_count == base, "R5 short burst", det_count, base);

    // R8: gapped burst with garbage on idle cycles
    base = det_count;
    noise(30);
    burst(160, 1'b0, 1'b1);
    noise(40);
    idle(3);
    check(det_count == base + 1, "R8 gapped burst detected", det_count, base + 1);
    check(cap_re == e_per, "R8 corr_re gapped", cap_re, e_per);
    check(cap_im == 0, "R8 corr_im gapped", cap_im, 0);

    // R6: thr=15 still detects a clean burst
    release_lock();
    thr = 4'd15;
    noise(40);
    base = det_count;
    burst(160, 1'b0, 1'b0);
    noise(20);
    idle(3);
    check(det_count == base + 1, "R6 thr15 burst", det_count, base + 1);

    // R6: thr=0 detects noise
    release_lock();
    thr = 4'd0;
    base = det_count;
    noise(120);
    idle(3);
    check(det_count == base + 1, "R6 thr0 noise", det_count, base + 1);
    check(pulse_bad == 0, "R9 pulse width overall", pulse_bad, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule